// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from power-up to a state where it accepts row activations. After reset it holds clock enable low and drives only no-operation commands until a stable-power delay has run out. It then issues a precharge of every bank, two auto-refresh commands and a mode-register load that carries a mode word supplied at an input. When the last required gap has passed, a ready flag rises. The ready flag tells the memory controller that it may start normal traffic.

Every wait is a parameter in nanoseconds and is converted to clock cycles at elaboration time, using the clock period parameter. The mode-register load gap is given directly in clocks. One parameter moves the mode-register load so that it comes right after the precharge instead of after the two refreshes. The data-mask lines stay high for the whole time. This block has no connection to the data bus.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and in the first sampled cycle after it, the outputs show CKE low, done low, the NOP pattern (CS#=0, RAS#=1, CAS#=1, WE#=1), address 0, bank 0 and DQM all ones.
- R2: Each nanosecond wait becomes ceil(t_ns / TCK_NS) cycles, with a minimum of 1. The tMRD wait is TMRD_CLK cycles, with a minimum of 1.
- R3: With P = ceil(POWERUP_NS / TCK_NS), the first non-NOP command appears P+1 cycles after the cycle in which reset falls. Before that, every cycle is a NOP.
- R4: The precharge command is CS#=0, RAS#=0, CAS#=1, WE#=0, with address bit AP_BIT (A10) high.
- R5: CKE rises exactly CKE_LEAD cycles before the precharge appears on the bus. It then stays high until reset.
- R6: An auto-refresh is CS#=0, RAS#=0, CAS#=0, WE#=1. The next command or the ready flag follows it after exactly the tRC cycle count.
- R7: The next command follows the precharge after exactly the tRP cycle count.
- R8: The mode-register load is CS#=0, RAS#=0, CAS#=0, WE#=0. It carries mode_i on the address bus and 0 on the bank bus. The next command or the ready flag follows it after exactly the tMRD count.
- R9: With MODE_FIRST=0 the order is precharge, refresh, refresh, mode load. With MODE_FIRST=1 it is precharge, mode load, refresh, refresh.
- R10: Exactly four non-NOP commands are issued per reset. No command other than NOP is ever issued while CKE is low.
- R11: DQM is all ones in every cycle.
- R12: done rises exactly one gap after the fourth command, where the gap belongs to that command's type. done then stays high, and only NOPs follow, until reset.
- R13: A reset asserted at any point in the sequence restarts it from the beginning, including the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | ADDR_W | Mode word placed on the address bus by the mode-register load |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| dqm_o | output | DQM_W | Data mask, held high |
| done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
The hardest cases to reach are a reset that lands in the middle of a gap, and gaps that collapse to a single cycle so that two commands sit back to back. The bench builds two small configurations. In the second one, the tRP wait comes out to one cycle and the mode load comes first. The bench sweeps the mode word with walking-one and walking-zero patterns. It also raises reset partway through the power-up wait and partway through a refresh gap, and then checks that the following run repeats the full timing exactly.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2,
    CMD_LMR = 2'd3
  } init_cmd_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int t_ns, input int tck_ns);
    int c;
    c = (t_ns + tck_ns - 1) / tck_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_order_sel.sv
module init_order_sel
  import sdram_init_pkg::*;
#(
  parameter bit MODE_FIRST = 1'b0
) (
  input  logic [1:0] step_i,
  output init_cmd_e  cmd_o
);

  generate
    if (MODE_FIRST) begin : g_mode_first
      always_comb begin
        case (step_i)
          2'd0:    cmd_o = CMD_PRE;
          2'd1:    cmd_o = CMD_LMR;
          default: cmd_o = CMD_REF;
        endcase
      end
    end else begin : g_refresh_first
      always_comb begin
        case (step_i)
          2'd0:    cmd_o = CMD_PRE;
          2'd3:    cmd_o = CMD_LMR;
          default: cmd_o = CMD_REF;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/init_wait_ctr.sv
module init_wait_ctr #(
  parameter int CW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= CW'(RST_VAL);
    end else if (ld_i) begin
      cnt_o <= ld_val_i;
    end else if (dec_i) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end

  assign zero_o = (cnt_o == '0);

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !ld_i) |-> !zero_o);

endmodule

// File: rtl/init_seq_fsm.sv
module init_seq_fsm
  import sdram_init_pkg::*;
#(
  parameter int P_CYC      = 100,
  parameter int GAP_RP     = 3,
  parameter int GAP_RC     = 10,
  parameter int GAP_MR     = 2,
  parameter int CKE_LEAD   = 4,
  parameter bit MODE_FIRST = 1'b0,
  parameter int CW         = 8
) (
  input  logic      clk,
  input  logic      rst,
  output init_cmd_e cmd_o,
  output logic      cke_o,
  output logic      done_o
);

  typedef enum logic [1:0] {ST_POWER, ST_ISSUE, ST_GAP, ST_DONE} seq_st_e;

  localparam logic [CW-1:0] GRP_V  = CW'(GAP_RP);
  localparam logic [CW-1:0] GRC_V  = CW'(GAP_RC);
  localparam logic [CW-1:0] GMR_V  = CW'(GAP_MR);
  localparam logic [CW-1:0] LEAD_V = CW'(CKE_LEAD);
  localparam logic [CW-1:0] TWO_V  = CW'(2);

  seq_st_e       st_q, st_d;
  logic [1:0]    step_q, step_d;
  init_cmd_e     step_cmd;
  logic [CW-1:0] gap_now;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ld_val;
  logic          ld, dec, zero;

  init_order_sel #(.MODE_FIRST(MODE_FIRST)) u_order (
    .step_i (step_q),
    .cmd_o  (step_cmd)
  );

  init_wait_ctr #(.CW(CW), .RST_VAL(P_CYC - 1)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .ld_i     (ld),
    .ld_val_i (ld_val),
    .dec_i    (dec),
    .cnt_o    (cnt),
    .zero_o   (zero)
  );

  always_comb begin
    case (step_cmd)
      CMD_PRE: gap_now = GRP_V;
      CMD_REF: gap_now = GRC_V;
      default: gap_now = GMR_V;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    ld     = 1'b0;
    ld_val = '0;
    dec    = 1'b0;
    case (st_q)
      ST_POWER: begin
        if (zero) begin
          st_d   = ST_ISSUE;
          step_d = 2'd0;
        end else begin
          dec = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (gap_now >= TWO_V) begin
          ld     = 1'b1;
          ld_val = gap_now - TWO_V;
          st_d   = ST_GAP;
        end else if (step_q == 2'd3) begin
          st_d = ST_DONE;
        end else begin
          step_d = step_q + 2'd1;
        end
      end
      ST_GAP: begin
        if (!zero) begin
          dec = 1'b1;
        end else if (step_q == 2'd3) begin
          st_d = ST_DONE;
        end else begin
          step_d = step_q + 2'd1;
          st_d   = ST_ISSUE;
        end
      end
      default: st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_POWER;
      step_q <= 2'd0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  assign cmd_o  = (st_q == ST_ISSUE) ? step_cmd : CMD_NOP;
  assign cke_o  = (st_q != ST_POWER) || (cnt < LEAD_V);
  assign done_o = (st_q == ST_DONE);

  // R3
  power_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_POWER && !zero) |=> st_q == ST_POWER);

  // R12
  done_state_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE) |=> st_q == ST_DONE);

  // R10
  last_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE) |-> step_q == 2'd3);

endmodule

// File: rtl/init_pin_reg.sv
module init_pin_reg
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BA_W   = 2,
  parameter int DQM_W  = 4,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  init_cmd_e         cmd_i,
  input  logic              cke_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] mode_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              done_o
);

  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << AP_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_o   <= 1'b0;
      cs_n_o  <= 1'b0;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      ba_o    <= '0;
      addr_o  <= '0;
      dqm_o   <= '1;
      done_o  <= 1'b0;
    end else begin
      cke_o  <= cke_i;
      done_o <= done_i;
      dqm_o  <= '1;
      cs_n_o <= 1'b0;
      ba_o   <= '0;
      case (cmd_i)
        CMD_PRE: begin
          ras_n_o <= 1'b0; cas_n_o <= 1'b1; we_n_o <= 1'b0;
          addr_o  <= ALL_BANKS;
        end
        CMD_REF: begin
          ras_n_o <= 1'b0; cas_n_o <= 1'b0; we_n_o <= 1'b1;
          addr_o  <= '0;
        end
        CMD_LMR: begin
          ras_n_o <= 1'b0; cas_n_o <= 1'b0; we_n_o <= 1'b0;
          addr_o  <= mode_i;
        end
        default: begin
          ras_n_o <= 1'b1; cas_n_o <= 1'b1; we_n_o <= 1'b1;
          addr_o  <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int TCK_NS     = 8,
  parameter int POWERUP_NS = 100000,
  parameter int TRP_NS     = 20,
  parameter int TRC_NS     = 80,
  parameter int TMRD_CLK   = 2,
  parameter int CKE_LEAD   = 4,
  parameter bit MODE_FIRST = 1'b0,
  parameter int ADDR_W     = 11,
  parameter int BA_W       = 2,
  parameter int DQM_W      = 4,
  parameter int AP_BIT     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mode_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              done_o
);

  localparam int P_CYC  = ns_to_cyc(POWERUP_NS, TCK_NS);
  localparam int G_RP   = ns_to_cyc(TRP_NS, TCK_NS);
  localparam int G_RC   = ns_to_cyc(TRC_NS, TCK_NS);
  localparam int G_MR   = max_int(TMRD_CLK, 1);
  localparam int BIGGEST = max_int(max_int(P_CYC, CKE_LEAD), max_int(G_RC, max_int(G_RP, G_MR)));
  localparam int CW     = $clog2(BIGGEST + 1) + 1;

  init_cmd_e fsm_cmd;
  logic      fsm_cke, fsm_done;

  init_seq_fsm #(
    .P_CYC      (P_CYC),
    .GAP_RP     (G_RP),
    .GAP_RC     (G_RC),
    .GAP_MR     (G_MR),
    .CKE_LEAD   (CKE_LEAD),
    .MODE_FIRST (MODE_FIRST),
    .CW         (CW)
  ) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .cmd_o  (fsm_cmd),
    .cke_o  (fsm_cke),
    .done_o (fsm_done)
  );

  init_pin_reg #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .DQM_W  (DQM_W),
    .AP_BIT (AP_BIT)
  ) u_pins (
    .clk     (clk),
    .rst     (rst),
    .cmd_i   (fsm_cmd),
    .cke_i   (fsm_cke),
    .done_i  (fsm_done),
    .mode_i  (mode_i),
    .cke_o   (cke_o),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o),
    .dqm_o   (dqm_o),
    .done_o  (done_o)
  );

  logic real_cmd;
  assign real_cmd = !cs_n_o && !(ras_n_o && cas_n_o && we_n_o);

  // R5
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cke_o |=> cke_o);

  // R10
  cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
    real_cmd |-> cke_o);

  // R12
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  // R12
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !real_cmd);

  // R8
  lmr_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (real_cmd && !ras_n_o && !cas_n_o && !we_n_o) |-> ba_o == '0);

endmodule

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  function automatic int cyc(input int ns, input int tck);
    int c;
    c = (ns + tck - 1) / tck;
    return (c < 1) ? 1 : c;
  endfunction

  // configuration A: refreshes before mode load
  localparam int A_TCK = 10, A_PWR = 300, A_TRP = 20, A_TRC = 75, A_MRD = 2, A_LEAD = 3;
  // configuration B: mode load first, single-cycle tRP gap
  localparam int B_TCK = 25, B_PWR = 250, B_TRP = 20, B_TRC = 80, B_MRD = 2, B_LEAD = 1;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [10:0] mode_a = '0, mode_b = '0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        cke;
    logic [3:0]  code;
    logic [1:0]  ba;
    logic [10:0] addr;
    logic [3:0]  dqm;
    logic        done;
  } pins_t;

  logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0] a_ba; logic [10:0] a_addr; logic [3:0] a_dqm;
  logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0] b_ba; logic [10:0] b_addr; logic [3:0] b_dqm;
  pins_t pa, pb;

  sdram_init_seq #(
    .TCK_NS(A_TCK), .POWERUP_NS(A_PWR), .TRP_NS(A_TRP), .TRC_NS(A_TRC),
    .TMRD_CLK(A_MRD), .CKE_LEAD(A_LEAD), .MODE_FIRST(1'b0)
  ) u_sdram_init_seq (
    .clk(clk), .rst(rst), .mode_i(mode_a), .cke_o(a_cke), .cs_n_o(a_cs),
    .ras_n_o(a_ras), .cas_n_o(a_cas), .we_n_o(a_we), .ba_o(a_ba),
    .addr_o(a_addr), .dqm_o(a_dqm), .done_o(a_done)
  );

  sdram_init_seq #(
    .TCK_NS(B_TCK), .POWERUP_NS(B_PWR), .TRP_NS(B_TRP), .TRC_NS(B_TRC),
    .TMRD_CLK(B_MRD), .CKE_LEAD(B_LEAD), .MODE_FIRST(1'b1)
  ) u_sdram_init_seq_alt (
    .clk(clk), .rst(rst), .mode_i(mode_b), .cke_o(b_cke), .cs_n_o(b_cs),
    .ras_n_o(b_ras), .cas_n_o(b_cas), .we_n_o(b_we), .ba_o(b_ba),
    .addr_o(b_addr), .dqm_o(b_dqm), .done_o(b_done)
  );

  always_comb begin
    pa = {a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_dqm, a_done};
    pb = {b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_dqm, b_done};
  end

  int checks = 0;
  int failures = 0;
  bit after_abort = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gap_of(input logic [3:0] c, input int grp, input int grc, input int gmr);
    if (c == C_PRE) return grp;
    if (c == C_REF) return grc;
    return gmr;
  endfunction

  task automatic run_seq(input bit which, input logic [10:0] mode, input int abort_k);
    int p, grp, grc, gmr, lead;
    bit mf;
    logic [3:0] exp_c[4];
    int exp_k[4];
    int ev_k[8];
    logic [3:0] ev_c[8];
    logic [10:0] ev_a[8];
    logic [1:0] ev_b[8];
    int n = 0, cke_k = -1, done_k = -1, exp_done;
    bit cke_drop = 0, done_drop = 0, dqm_bad = 0, nop_bad = 0;
    pins_t s;

    p    = which ? cyc(B_PWR, B_TCK) : cyc(A_PWR, A_TCK);
    grp  = which ? cyc(B_TRP, B_TCK) : cyc(A_TRP, A_TCK);
    grc  = which ? cyc(B_TRC, B_TCK) : cyc(A_TRC, A_TCK);
    gmr  = which ? B_MRD : A_MRD;
    lead = which ? B_LEAD : A_LEAD;
    mf   = which;

    exp_c[0] = C_PRE;
    exp_c[1] = mf ? C_LMR : C_REF;
    exp_c[2] = C_REF;
    exp_c[3] = mf ? C_REF : C_LMR;
    exp_k[0] = p + 1;
    for (int i = 1; i < 4; i++) exp_k[i] = exp_k[i-1] + gap_of(exp_c[i-1], grp, grc, gmr);
    exp_done = exp_k[3] + gap_of(exp_c[3], grp, grc, gmr);

    if (which) mode_b = mode; else mode_a = mode;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    s = which ? pb : pa;
    // R1 reset state
    chk(s.cke == 1'b0 && s.done == 1'b0, "R1", "cke/done in reset", {s.cke, s.done}, 0);
    chk(s.code == C_NOP && s.addr == '0 && s.ba == '0 && s.dqm == 4'hF,
        "R1", "bus in reset", {s.code, s.dqm}, {C_NOP, 4'hF});
    rst = 1'b0;

    for (int k = 1; k <= 400; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (abort_k > 0 && k == abort_k) begin
        rst = 1'b1;
        after_abort = 1'b1;
        return;
      end
      s = which ? pb : pa;
      if (k == 1) chk(s.code[2:0] == 3'b111 || s.code[3], "R1", "first cycle after reset", s.code, C_NOP);
      if (s.dqm != 4'hF) dqm_bad = 1'b1;
      if (s.cke && cke_k < 0) cke_k = k;
      if (!s.cke && cke_k >= 0) cke_drop = 1'b1;
      if (!s.code[3] && s.code[2:0] != 3'b111) begin
        if (n < 8) begin
          ev_k[n] = k; ev_c[n] = s.code; ev_a[n] = s.addr; ev_b[n] = s.ba;
        end
        n++;
      end else if (s.addr != '0 || s.ba != '0) begin
        nop_bad = 1'b1;
      end
      if (s.done && done_k < 0) done_k = k;
      if (!s.done && done_k >= 0) done_drop = 1'b1;
      if (done_k >= 0 && k >= done_k + 6) break;
    end

    chk(n == 4, "R10", "command count", n, 4);
    chk(!nop_bad, "R10", "idle cycles not clean NOP", nop_bad, 0);
    chk(!dqm_bad, "R11", "dqm dropped", dqm_bad, 0);
    chk(cke_k == p + 1 - lead, "R5", "cke rise cycle", cke_k, p + 1 - lead);
    chk(!cke_drop, "R5", "cke fell", cke_drop, 0);
    if (n >= 1) begin
      chk(ev_k[0] == exp_k[0], "R3", "precharge cycle", ev_k[0], exp_k[0]);
      chk(ev_c[0] == C_PRE && ev_a[0][10], "R4", "precharge pattern/A10", {ev_c[0], ev_a[0][10]}, {C_PRE, 1'b1});
      if (after_abort) chk(ev_k[0] == exp_k[0], "R13", "restart wait", ev_k[0], exp_k[0]);
    end
    for (int i = 1; i < 4 && i < n; i++) begin
      chk(ev_c[i] == exp_c[i], "R9", "command order", ev_c[i], exp_c[i]);
      // R2 R6 R7 R8: gap after previous command
      chk(ev_k[i] == exp_k[i], (exp_c[i-1] == C_PRE) ? "R7" : ((exp_c[i-1] == C_REF) ? "R6" : "R8"),
          "command cycle (R2 gap)", ev_k[i], exp_k[i]);
      if (ev_c[i] == C_LMR) begin
        chk(ev_a[i] == mode, "R8", "mode on address", ev_a[i], mode);
        chk(ev_b[i] == 2'b00, "R8", "bank at mode load", ev_b[i], 0);
      end
    end
    chk(done_k == exp_done, "R12", "done cycle", done_k, exp_done);
    chk(!done_drop, "R12", "done fell", done_drop, 0);
    after_abort = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int b = 0; b < 11; b++) run_seq(1'b0, 11'(1) << b, 0);
    run_seq(1'b0, 11'h000, 0);
    run_seq(1'b0, 11'h7FF, 0);
    run_seq(1'b0, 11'h555, 0);
    run_seq(1'b0, 11'h2AA, 0);
    for (int b = 0; b < 11; b += 3) run_seq(1'b1, ~(11'(1) << b), 0);
    // R13 reset inside the power-up wait, then inside a refresh gap
    run_seq(1'b0, 11'h123, 10);
    run_seq(1'b0, 11'h123, 0);
    run_seq(1'b0, 11'h321, 38);
    run_seq(1'b0, 11'h321, 0);
    run_seq(1'b1, 11'h0F0, 13);
    run_seq(1'b1, 11'h0F0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule